// File: doc/BRIEF.md
# CAN Receive Record FIFO

This block is the receive store of a CAN controller. Frames that have already passed acceptance filtering arrive as a parallel frame word: the extended flag, the remote flag, the length code, the identifier and eight data bytes. The block turns each frame into a variable-length byte record and writes that record into a circular byte buffer, one byte per clock. A frame is stored whole or not at all. When the record would not fit in the free space, the frame is dropped and an overrun is flagged.

The host looks into the buffer through a window of 13 bytes that starts at the oldest stored record. It frees that record with a release command. The block finds the length of the record from the record's own header byte and moves the read start past it. Status and interrupt bytes report three conditions: a stored message is waiting, a frame is being received, and an overrun occurred. A mode-entry strobe empties the buffer.

Top module: `can_rx_record_fifo`

## Requirements
- R1: A standard record holds a header byte {ext, rtr, 2'b00, dlc[3:0]}, then id[10:3], then {id[2:0], 5'b0}, then the data bytes, with data byte k taken from frm_data[8k+7:8k].
- R2: An extended record holds the header byte, then id[28:21], id[20:13] and id[12:5], then {id[4:0], 3'b0}, then the data bytes.
- R3: A record is 3+DLC bytes long for a standard frame and 5+DLC bytes long for an extended frame. A remote frame stores no data bytes but keeps its DLC in the header. A successful store adds the record length to byte_count and adds one to msg_count.
- R4: A release with at least one message stored does three things: it reads the header at the read start, moves the read start forward by that record's length modulo the capacity, and lowers byte_count by the length and msg_count by one.
- R5: A release while msg_count is 0 has no effect on the counts, the flags or the read start.
- R6: A frame whose record would make byte_count exceed the capacity (64 bytes by default) is not stored, and the counts do not change. The frame sets overrun status bit sts_o[1] and overrun interrupt bit intf_o[3]. A record that exactly fills the buffer is stored.
- R7: Receive-buffer status sts_o[0] and receive interrupt intf_o[0] become 1 after a successful store. Both return to 0 when a release brings msg_count to 0.
- R8: Receiving status sts_o[4] is 1 from the cycle after a frame is taken until the store ends or the frame is rejected. frm_ready is low for that whole time.
- R9: A frame with DLC greater than 8 is rejected. Nothing is stored, and no overrun is flagged.
- R10: op_enter clears byte_count, msg_count and intf_o[0]. The next stored record then starts at the current read start.
- R11: win_data returns the byte at (read start + win_ofs) modulo the capacity for win_ofs from 0 to 12, and returns 0 for win_ofs from 13 to 15.
- R12: clr_ovr clears sts_o[1] and intf_o[3]. A new overrun in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | A filtered frame is presented |
| frm_ready | output | 1 | The block is idle and takes a frame |
| frm_ext | input | 1 | Extended identifier frame |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_id | input | 29 | Identifier, right aligned |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_cmd | input | 1 | Release the head record |
| clr_ovr | input | 1 | Clear the overrun flags |
| op_enter | input | 1 | Enter operating mode and empty the buffer |
| win_ofs | input | 4 | Offset into the read window |
| win_data | output | 8 | Byte at the read start plus the offset |
| sts_o | output | 8 | Status: bit 0 message waiting, bit 1 overrun, bit 4 receiving |
| intf_o | output | 8 | Interrupt flags: bit 0 receive, bit 3 overrun |
| byte_count | output | 7 | Bytes held in the buffer |
| msg_count | output | 7 | Records held in the buffer |

## Verification
The store path is driven with four frame kinds: standard with data, extended with data, standard remote and extended remote. These separate the two identifier layouts from each other, and the data-bearing length from the remote length. A run of full extended frames, each released as soon as it is stored, pushes the read start across the end of the buffer. This shows whether the window and the release step wrap correctly. A fill sequence stores a record that lands on exactly 64 bytes and then offers one more. This tells "exceeds capacity" apart from "reaches capacity". A frame with an oversized length code, an empty release and a mode entry with records still stored show that each of these is rejected or clears the buffer without disturbing anything else.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

   typedef struct packed {
      logic        ext;
      logic        rtr;
      logic [3:0]  dlc;
      logic [28:0] id;
      logic [63:0] data;
   } rxf_frame_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVAL  = 2'd1,
      ST_STORE = 2'd2
   } rxf_state_e;

   // Record length in bytes: header plus ID bytes, plus data unless remote.
   function automatic logic [4:0] rec_len(input logic ext, input logic rtr,
                                          input logic [3:0] dlc);
      logic [4:0] n;
      n = ext ? 5'd5 : 5'd3;
      if (!rtr) n = n + {1'b0, dlc};
      return n;
   endfunction

endpackage

// File: rtl/can_rxf_byte_sel.sv
module can_rxf_byte_sel
   import can_rxf_pkg::*;
(
   input  rxf_frame_t  frm,
   input  logic [3:0]  idx,
   output logic [7:0]  byte_o
);

   logic [2:0] base;
   logic [2:0] k;
   logic [7:0] data_b;

   always_comb begin
      base   = frm.ext ? 3'd5 : 3'd3;
      k      = idx[2:0] - base;          // wraps modulo 8, idx <= 12
      data_b = frm.data[{k, 3'b000} +: 8];
      if (idx == 4'd0) begin
         byte_o = {frm.ext, frm.rtr, 2'b00, frm.dlc};
      end else if (frm.ext) begin
         case (idx)
            4'd1:    byte_o = frm.id[28:21];
            4'd2:    byte_o = frm.id[20:13];
            4'd3:    byte_o = frm.id[12:5];
            4'd4:    byte_o = {frm.id[4:0], 3'b000};
            default: byte_o = data_b;
         endcase
      end else begin
         case (idx)
            4'd1:    byte_o = frm.id[10:3];
            4'd2:    byte_o = {frm.id[2:0], 5'b00000};
            default: byte_o = data_b;
         endcase
      end
   end

endmodule

// File: rtl/can_rxf_ram.sv
module can_rxf_ram #(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/can_rx_record_fifo.sv
module can_rx_record_fifo
   import can_rxf_pkg::*;
#(
   parameter  int CAP_BYTES = 64,
   parameter  int WIN_BYTES = 13,
   localparam int AW        = $clog2(CAP_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_valid,
   output logic          frm_ready,
   input  logic          frm_ext,
   input  logic          frm_rtr,
   input  logic [3:0]    frm_dlc,
   input  logic [28:0]   frm_id,
   input  logic [63:0]   frm_data,
   input  logic          rel_cmd,
   input  logic          clr_ovr,
   input  logic          op_enter,
   input  logic [3:0]    win_ofs,
   output logic [7:0]    win_data,
   output logic [7:0]    sts_o,
   output logic [7:0]    intf_o,
   output logic [AW:0]   byte_count,
   output logic [AW:0]   msg_count
);

   localparam int CW = AW + 1;

   // Elaboration checks on the parameter set.
   if ((1 << AW) != CAP_BYTES) begin : g_cap_pow2
      $error("CAP_BYTES must be a power of two");
   end
   if (CAP_BYTES < 16) begin : g_cap_min
      $error("CAP_BYTES must hold at least one full extended record");
   end
   if (WIN_BYTES < 13 || WIN_BYTES > 16) begin : g_win_rng
      $error("WIN_BYTES must lie in 13..16");
   end

   rxf_frame_t   frm_q;
   rxf_state_e   state;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [3:0]   idx;
   logic [4:0]   cur_len;
   logic [CW-1:0] byte_cnt, msg_cnt;
   logic         ovr_st, ovr_irq, irq_rx;
   logic [7:0]   head_byte, store_byte, win_raw;
   logic [4:0]   eval_len, rel_len;
   logic         bad_dlc, fits, store_commit, rel_ok, ovr_hit;
   logic         unused_hdr_bits;

   can_rxf_byte_sel i_sel (
      .frm    (frm_q),
      .idx    (idx),
      .byte_o (store_byte)
   );

   can_rxf_ram #(.DEPTH(CAP_BYTES)) i_ram (
      .clk     (clk),
      .we      (state == ST_STORE),
      .waddr   (wr_ptr),
      .wdata   (store_byte),
      .raddr_a (rd_ptr),
      .rdata_a (head_byte),
      .raddr_b (rd_ptr + AW'(win_ofs)),
      .rdata_b (win_raw)
   );

   assign unused_hdr_bits = ^head_byte[5:4];

   always_comb begin
      eval_len     = rec_len(frm_q.ext, frm_q.rtr, frm_q.dlc);
      bad_dlc      = frm_q.dlc > 4'd8;
      fits         = ({1'b0, byte_cnt} + (CW+1)'(eval_len)) <= (CW+1)'(CAP_BYTES);
      store_commit = (state == ST_STORE) && ({1'b0, idx} == cur_len - 5'd1);
      rel_ok       = rel_cmd && (msg_cnt != '0);
      rel_len      = rec_len(head_byte[7], head_byte[6], head_byte[3:0]);
      ovr_hit      = (state == ST_EVAL) && !bad_dlc && !fits && !op_enter;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         frm_q    <= '0;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         idx      <= '0;
         cur_len  <= '0;
         byte_cnt <= '0;
         msg_cnt  <= '0;
         irq_rx   <= 1'b0;
      end else if (op_enter) begin
         state    <= ST_IDLE;
         byte_cnt <= '0;
         msg_cnt  <= '0;
         wr_ptr   <= rd_ptr;
         irq_rx   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (frm_valid) begin
                  frm_q <= '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc,
                             id: frm_id, data: frm_data};
                  state <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (bad_dlc || !fits) begin
                  state <= ST_IDLE;
               end else begin
                  state   <= ST_STORE;
                  idx     <= '0;
                  cur_len <= eval_len;
               end
            end
            ST_STORE: begin
               wr_ptr <= wr_ptr + 1'b1;
               idx    <= idx + 4'd1;
               if (store_commit) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
         byte_cnt <= byte_cnt + (store_commit ? CW'(cur_len) : '0)
                              - (rel_ok ? CW'(rel_len) : '0);
         msg_cnt  <= msg_cnt + CW'(store_commit) - CW'(rel_ok);
         if (rel_ok) rd_ptr <= rd_ptr + AW'(rel_len);
         if (store_commit) irq_rx <= 1'b1;
         else if (rel_ok && msg_cnt == CW'(1)) irq_rx <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_st  <= 1'b0;
         ovr_irq <= 1'b0;
      end else if (ovr_hit) begin
         ovr_st  <= 1'b1;
         ovr_irq <= 1'b1;
      end else if (clr_ovr) begin
         ovr_st  <= 1'b0;
         ovr_irq <= 1'b0;
      end
   end

   assign frm_ready  = (state == ST_IDLE);
   assign win_data   = (32'(win_ofs) < WIN_BYTES) ? win_raw : 8'h00;
   assign sts_o      = {3'b000, state != ST_IDLE, 2'b00, ovr_st, msg_cnt != '0};
   assign intf_o     = {4'b0000, ovr_irq, 2'b00, irq_rx};
   assign byte_count = byte_cnt;
   assign msg_count  = msg_cnt;

endmodule

// File: rtl/can_rx_record_fifo_chk.sv
module can_rx_record_fifo_chk #(
   parameter int CAP_BYTES = 64,
   parameter int CW        = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frm_valid,
   input logic          rel_cmd,
   input logic          op_enter,
   input logic          store_commit,
   input logic          recv,
   input logic          sts_ovr,
   input logic          irq_ovr,
   input logic          irq_rx,
   input logic [CW-1:0] byte_count,
   input logic [CW-1:0] msg_count
);

   AST_BYTES_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      byte_count <= CW'(CAP_BYTES)); // R6

   AST_MSG_BYTES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_count == '0) == (byte_count == '0)); // R3

   AST_EMPTY_RELEASE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_cmd && msg_count == '0 && !store_commit && !op_enter)
      |=> (msg_count == '0 && byte_count == '0)); // R5

   AST_RXIRQ_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (msg_count != '0)); // R7

   AST_RECV_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recv) |-> $past(frm_valid)); // R8

   AST_OP_CLEARS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      op_enter |=> (msg_count == '0 && byte_count == '0)); // R10

   AST_OVR_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      sts_ovr == irq_ovr); // R12

endmodule

bind can_rx_record_fifo can_rx_record_fifo_chk #(
   .CAP_BYTES (CAP_BYTES),
   .CW        (AW + 1)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frm_valid    (frm_valid),
   .rel_cmd      (rel_cmd),
   .op_enter     (op_enter),
   .store_commit (store_commit),
   .recv         (sts_o[4]),
   .sts_ovr      (sts_o[1]),
   .irq_ovr      (intf_o[3]),
   .irq_rx       (intf_o[0]),
   .byte_count   (byte_count),
   .msg_count    (msg_count)
);

// File: tb/test_can_rx_record_fifo.sv
module test_can_rx_record_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int CAP        = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
   logic [3:0]  frm_dlc = '0;
   logic [28:0] frm_id = '0;
   logic [63:0] frm_data = '0;
   logic        rel_cmd = 1'b0, clr_ovr = 1'b0, op_enter = 1'b0;
   logic [3:0]  win_ofs = '0;
   logic        frm_ready;
   logic [7:0]  win_data, sts_o, intf_o;
   logic [6:0]  byte_count, msg_count;

   can_rx_record_fifo i_can_rx_record_fifo (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
      .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_id(frm_id),
      .frm_data(frm_data), .rel_cmd(rel_cmd), .clr_ovr(clr_ovr),
      .op_enter(op_enter), .win_ofs(win_ofs), .win_data(win_data),
      .sts_o(sts_o), .intf_o(intf_o), .byte_count(byte_count),
      .msg_count(msg_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Scoreboard state
   logic [7:0] exp_q[$];
   int         len_q[$];
   string      tag_q[$];
   int         m_bytes = 0, m_msgs = 0;
   int         n_chk = 0, n_fail = 0;
   bit         finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_counts(input string req);
      chk({req, " byte_count"}, 32'(byte_count), 32'(m_bytes));
      chk({req, " msg_count"},  32'(msg_count),  32'(m_msgs));
   endtask

   // Driver: presents a frame and pushes its expected record.
   task automatic send(input logic ext, input logic rtr, input logic [3:0] dlc,
                       input logic [28:0] id, input logic [63:0] data);
      int len;
      @(negedge clk);
      while (!frm_ready) @(negedge clk);
      frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc; frm_id = id; frm_data = data;
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      chk("R8 receiving while busy", 32'(sts_o[4]), 32'd1);
      chk("R8 not ready while busy", 32'(frm_ready), 32'd0);
      while (!frm_ready) @(negedge clk);
      chk("R8 receiving cleared", 32'(sts_o[4]), 32'd0);
      len = (ext ? 5 : 3) + ((rtr || dlc > 8) ? 0 : int'(dlc));
      if (dlc > 4'd8) begin
         chk_counts("R9 oversized DLC rejected");
      end else if (m_bytes + len > CAP) begin
         chk("R6 overrun status", 32'(sts_o[1]), 32'd1);
         chk("R6 overrun interrupt", 32'(intf_o[3]), 32'd1);
         chk_counts("R6 nothing stored");
      end else begin
         exp_q.push_back({ext, rtr, 2'b00, dlc});
         if (ext) begin
            exp_q.push_back(id[28:21]);
            exp_q.push_back(id[20:13]);
            exp_q.push_back(id[12:5]);
            exp_q.push_back({id[4:0], 3'b000});
         end else begin
            exp_q.push_back(id[10:3]);
            exp_q.push_back({id[2:0], 5'b00000});
         end
         if (!rtr) for (int k = 0; k < int'(dlc); k++) exp_q.push_back(data[8*k +: 8]);
         len_q.push_back(len);
         tag_q.push_back(ext ? "R2 extended record byte" : "R1 standard record byte");
         m_bytes += len;
         m_msgs++;
         chk_counts("R3 store length");
         chk("R7 rx status set", 32'(sts_o[0]), 32'd1);
         chk("R7 rx interrupt set", 32'(intf_o[0]), 32'd1);
      end
   endtask

   // Monitor: compares the window with the head record, then releases it.
   task automatic release_chk(input string over_tag);
      int    len;
      string tag;
      @(negedge clk);
      if (len_q.size() == 0) begin
         rel_cmd = 1'b1;
         @(negedge clk);
         rel_cmd = 1'b0;
         chk_counts("R5 empty release ignored");
         chk("R5 rx status stays clear", 32'(sts_o[0]), 32'd0);
         chk("R5 rx interrupt stays clear", 32'(intf_o[0]), 32'd0);
         return;
      end
      len = len_q.pop_front();
      tag = tag_q.pop_front();
      if (over_tag != "") tag = over_tag;
      for (int o = 0; o < len; o++) begin
         win_ofs = 4'(o);
         #1;
         chk(tag, 32'(win_data), 32'(exp_q.pop_front()));
      end
      win_ofs = '0;
      rel_cmd = 1'b1;
      @(negedge clk);
      rel_cmd = 1'b0;
      m_bytes -= len;
      m_msgs--;
      chk_counts("R4 release");
      if (m_msgs == 0) begin
         chk("R7 rx status cleared", 32'(sts_o[0]), 32'd0);
         chk("R7 rx interrupt cleared", 32'(intf_o[0]), 32'd0);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset frm_ready", 32'(frm_ready), 32'd1);
      chk("reset sts_o", 32'(sts_o), 32'd0);
      chk("reset intf_o", 32'(intf_o), 32'd0);
      chk_counts("reset");

      // Four frame kinds: R1, R2, R3
      send(1'b0, 1'b0, 4'd2, 29'h123, 64'h0000_0000_0000_BBAA);
      send(1'b1, 1'b0, 4'd8, 29'h1ABC_DE12, 64'h8877_6655_4433_2211);
      send(1'b0, 1'b1, 4'd4, 29'h7FF, 64'hFFFF_FFFF_FFFF_FFFF);
      send(1'b1, 1'b1, 4'd0, 29'h0000_0015, 64'h0);
      // Oversized DLC: R9
      send(1'b0, 1'b0, 4'd9, 29'h055, 64'h1234);
      chk("R9 no overrun flagged", 32'(sts_o[1]), 32'd0);
      repeat (4) release_chk("");
      release_chk("");   // empty: R5

      // Read start crosses the end of the buffer: R11
      for (int i = 0; i < 6; i++) begin
         send(1'b1, 1'b0, 4'd8, 29'h0ABC_0000 + 29'(i),
              64'h0102_0304_0506_0708 ^ {8{8'(i * 37)}});
         release_chk("R11 wrapped window byte");
      end

      // Offsets past the window read as zero: R11
      send(1'b0, 1'b0, 4'd1, 29'h3C5, 64'h5A);
      @(negedge clk);
      for (int o = 13; o < 16; o++) begin
         win_ofs = 4'(o);
         #1;
         chk("R11 offset outside window", 32'(win_data), 32'd0);
      end
      win_ofs = '0;
      release_chk("");

      // Fill to exactly 64, then overflow: R6
      for (int i = 0; i < 4; i++)
         send(1'b1, 1'b0, 4'd8, 29'h1000_0000 | 29'(i), {8{8'(i + 1)}});
      send(1'b1, 1'b0, 4'd7, 29'h0F0F_0F0F, 64'h00EE_DDCC_BBAA_9988);
      chk("R6 exact fill stored", 32'(byte_count), 32'd64);
      send(1'b0, 1'b1, 4'd0, 29'h001, 64'h0);
      @(negedge clk);
      clr_ovr = 1'b1;
      @(negedge clk);
      clr_ovr = 1'b0;
      chk("R12 overrun status cleared", 32'(sts_o[1]), 32'd0);
      chk("R12 overrun interrupt cleared", 32'(intf_o[3]), 32'd0);
      repeat (5) release_chk("");

      // Mode entry with records held: R10
      send(1'b0, 1'b0, 4'd3, 29'h222, 64'h00_3333_44);
      send(1'b1, 1'b0, 4'd2, 29'h0033_3333, 64'h6655);
      @(negedge clk);
      op_enter = 1'b1;
      @(negedge clk);
      op_enter = 1'b0;
      exp_q.delete(); len_q.delete(); tag_q.delete();
      m_bytes = 0; m_msgs = 0;
      chk_counts("R10 mode entry clears");
      chk("R10 rx interrupt cleared", 32'(intf_o[0]), 32'd0);
      send(1'b0, 1'b0, 4'd2, 29'h4A1, 64'hC3B2);
      release_chk("R10 record after mode entry");

      finished = 1;
      summary();
      $finish;
   end

endmodule